// File: doc/BRIEF.md
# Colour LCD Controller Register Block

This block is the register file of a colour LCD controller. It answers a simple 32-bit slave bus that addresses words inside a 4 KB window. Through it, software programs four panel timing words, the base addresses of the upper and lower frame buffers, a control word and an interrupt mask. Software can also read the raw and masked interrupt status and clear status bits. Near the top of the window sits a read-only block of eight identification bytes.

From the stored timing words the block derives the panel width in pixels and the height in lines. From the control word it derives an enabled flag and a pixel-depth code. Each write pulses a redraw request so that downstream display logic repaints the frame. A static strap input selects a board variant in which the control word and the interrupt mask exchange their two word offsets.

An event input vector sets raw status bits. The interrupt output is the OR of the raw status bits that the mask allows. Accesses outside the mapped offsets read as zero, have no effect when written, and pulse an error output.

Top module: `lcdc_regs`

## Requirements
- R1: After reset, whether at power-up or asserted in mid-run, every storage register reads zero. At that point the outputs are: irq_out 0, ctrl_enabled 0, pix_depth 0, panel_width 16, panel_height 1.
- R2: Word offsets 0 to 3 (timing words 0 to 3), 4 (upper base) and 5 (lower base) store all 32 written bits and read them back. Word offset 11 reads the upper base and word offset 12 reads the lower base; writes to 11 and 12 have no effect.
- R3: With variant_sel=0, word offset 6 is the interrupt mask and word offset 7 is the control word. With variant_sel=1 the two are exchanged, for reads and for writes alike.
- R4: The mask keeps the low IW=4 written bits and reads zero-extended. Word offset 9 reads raw status AND mask. irq_out is 1 exactly when that masked value is nonzero.
- R5: Word offset 8 reads the raw status. A 1 on an irq_set bit sets that raw bit at the next edge. Writing word offset 10 clears each raw bit whose written bit is 1. When set and clear hit the same bit in the same cycle, set wins. Offset 10 reads zero.
- R6: Word offsets 0x3F8 to 0x3FF read the bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended. Writes to them have no effect and raise no error.
- R7: panel_width = ((timing0 AND 0xFC) + 4) * 4 and panel_height = (timing1 AND 0x3FF) + 1. Both reflect a timing write right after the edge that captures it.
- R8: The control word keeps its low 16 bits. ctrl_enabled = bit 0 AND bit 11, and pix_depth = bits 3:1. Both follow the stored control word.
- R9: Every captured write, whether mapped or not, makes redraw_pulse 1 for exactly the following cycle. When there is no write, redraw_pulse is 0.
- R10: A read or write to an offset outside 0 to 12 and 0x3F8 to 0x3FF reads zero, changes no register, and makes bus_err 1 for the following cycle. Mapped accesses leave bus_err at 0.
- R11: bus_rdata carries the value read one cycle after the read is captured, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| variant_sel | input | 1 | Board variant strap: swaps control and mask offsets |
| irq_set | input | 4 | Event inputs that set raw status bits |
| irq_out | output | 1 | OR of masked status bits |
| redraw_pulse | output | 1 | One-cycle pulse after each write |
| panel_width | output | 11 | Derived panel width in pixels |
| panel_height | output | 11 | Derived panel height in lines |
| ctrl_enabled | output | 1 | Enable and power bits both set |
| pix_depth | output | 3 | Pixel depth code from the control word |

## Verification
Read data, bus_err and redraw_pulse come from registers. Each is due in the cycle after the edge that captures the access. The bench drives an access on a falling edge and samples these outputs on the next falling edge. panel_width, panel_height, ctrl_enabled, pix_depth and irq_out are decoded from stored state without a further register. They are therefore checked at that same falling edge after a write or after an irq_set pulse. Hold behaviour is checked after a further idle cycle: redraw_pulse and bus_err must drop back to zero, and bus_rdata must not change.

// File: rtl/lcdc_regs_pkg.sv
package lcdc_regs_pkg;

  localparam int NUM_TIM   = 4;
  localparam int WFLD_LSB  = 2;
  localparam int WFLD_W    = 6;
  localparam int HFLD_W    = 10;
  localparam int WIDTH_W   = WFLD_W + 1 + 4;
  localparam int HEIGHT_W  = HFLD_W + 1;
  localparam int CB_EN     = 0;
  localparam int CB_PWR    = 11;
  localparam int CB_DEP_LO = 1;
  localparam int DEPTH_W   = 3;

  typedef enum logic [3:0] {
    SEL_TIM, SEL_UPB, SEL_LPB, SEL_MASK, SEL_CTRL, SEL_RIS, SEL_MIS,
    SEL_ICR, SEL_UPCUR, SEL_LPCUR, SEL_ID, SEL_NONE
  } reg_sel_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h10;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_addr_decode.sv
module lcdc_addr_decode
  import lcdc_regs_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  input  logic          variant,
  output reg_sel_e      sel,
  output logic [1:0]    tim_idx,
  output logic [2:0]    id_idx
);

  localparam logic [AW-1:0] ID_BASE = AW'((1 << AW) - 8);

  assign tim_idx = addr[1:0];
  assign id_idx  = addr[2:0];

  always_comb begin
    sel = SEL_NONE;
    if (addr >= ID_BASE) begin
      sel = SEL_ID;
    end else begin
      case (addr)
        AW'(0), AW'(1), AW'(2), AW'(3): sel = SEL_TIM;
        AW'(4):  sel = SEL_UPB;
        AW'(5):  sel = SEL_LPB;
        AW'(6):  sel = variant ? SEL_CTRL : SEL_MASK;
        AW'(7):  sel = variant ? SEL_MASK : SEL_CTRL;
        AW'(8):  sel = SEL_RIS;
        AW'(9):  sel = SEL_MIS;
        AW'(10): sel = SEL_ICR;
        AW'(11): sel = SEL_UPCUR;
        AW'(12): sel = SEL_LPCUR;
        default: sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/lcdc_irq_status.sv
module lcdc_irq_status #(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] set_i,
  input  logic          clr_we,
  input  logic [IW-1:0] clr_data,
  input  logic          mask_we,
  input  logic [IW-1:0] mask_wdata,
  output logic [IW-1:0] raw_o,
  output logic [IW-1:0] mask_o,
  output logic [IW-1:0] masked_o,
  output logic          irq_o
);

  logic [IW-1:0] raw_q, raw_d, mask_q, clr_vec;

  always_comb begin
    clr_vec = clr_we ? clr_data : '0;
    raw_d   = (raw_q & ~clr_vec) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
  assign irq_o    = |masked_o;

  // R5: an event bit is present in raw status at the next edge
  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i)));

  // R5: a clear with no coincident event empties the written bits
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((clr_data & set_i) == '0)) |=> ((raw_q & $past(clr_data)) == '0));

  // R4: a zero mask silences the interrupt
  p_mask_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && (mask_wdata == '0)) |=> !irq_o);

endmodule

// File: rtl/lcdc_panel_cfg.sv
module lcdc_panel_cfg
  import lcdc_regs_pkg::*;
(
  input  logic [WFLD_W-1:0]   w_fld,
  input  logic [HFLD_W-1:0]   h_fld,
  input  logic                en_bit,
  input  logic                pwr_bit,
  input  logic [DEPTH_W-1:0]  dep_fld,
  output logic [WIDTH_W-1:0]  width,
  output logic [HEIGHT_W-1:0] height,
  output logic                enabled,
  output logic [DEPTH_W-1:0]  depth
);

  logic [WFLD_W:0] w_units;

  assign w_units = {1'b0, w_fld} + 1'b1;
  assign width   = {w_units, 4'b0000};
  assign height  = {1'b0, h_fld} + 1'b1;
  assign enabled = en_bit & pwr_bit;
  assign depth   = dep_fld;

endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_regs_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int IW = 4,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                bus_err,
  input  logic                variant_sel,
  input  logic [IW-1:0]       irq_set,
  output logic                irq_out,
  output logic                redraw_pulse,
  output logic [WIDTH_W-1:0]  panel_width,
  output logic [HEIGHT_W-1:0] panel_height,
  output logic                ctrl_enabled,
  output logic [DEPTH_W-1:0]  pix_depth
);

  localparam int TIW = $clog2(NUM_TIM);

  reg_sel_e   sel;
  logic [1:0] tim_idx;
  logic [2:0] id_idx;
  logic       wr_acc, rd_acc;

  assign wr_acc = bus_en & bus_we;
  assign rd_acc = bus_en & ~bus_we;

  lcdc_addr_decode #(.AW(AW)) i_dec (
    .addr(bus_addr), .variant(variant_sel),
    .sel(sel), .tim_idx(tim_idx), .id_idx(id_idx)
  );

  // timing words
  logic [NUM_TIM-1:0][DW-1:0] tim_q;
  for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
    logic          we;
    logic [DW-1:0] q;
    assign we = wr_acc && (sel == SEL_TIM) && (tim_idx[TIW-1:0] == TIW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= bus_wdata;
    end
    assign tim_q[g] = q;
  end

  // base addresses and control
  logic [DW-1:0] upb_q, lpb_q;
  logic [CW-1:0] ctrl_q;
  logic          upb_we, lpb_we, ctrl_we;

  assign upb_we  = wr_acc && (sel == SEL_UPB);
  assign lpb_we  = wr_acc && (sel == SEL_LPB);
  assign ctrl_we = wr_acc && (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upb_q  <= '0;
      lpb_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (upb_we)  upb_q  <= bus_wdata;
      if (lpb_we)  lpb_q  <= bus_wdata;
      if (ctrl_we) ctrl_q <= bus_wdata[CW-1:0];
    end
  end

  // interrupts
  logic [IW-1:0] raw_v, mask_v, masked_v;

  lcdc_irq_status #(.IW(IW)) i_irq (
    .clk(clk), .rst_n(rst_n), .set_i(irq_set),
    .clr_we(wr_acc && (sel == SEL_ICR)), .clr_data(bus_wdata[IW-1:0]),
    .mask_we(wr_acc && (sel == SEL_MASK)), .mask_wdata(bus_wdata[IW-1:0]),
    .raw_o(raw_v), .mask_o(mask_v), .masked_o(masked_v), .irq_o(irq_out)
  );

  // derived panel configuration
  lcdc_panel_cfg i_cfg (
    .w_fld(tim_q[0][WFLD_LSB +: WFLD_W]), .h_fld(tim_q[1][HFLD_W-1:0]),
    .en_bit(ctrl_q[CB_EN]), .pwr_bit(ctrl_q[CB_PWR]),
    .dep_fld(ctrl_q[CB_DEP_LO +: DEPTH_W]),
    .width(panel_width), .height(panel_height),
    .enabled(ctrl_enabled), .depth(pix_depth)
  );

  // read path, error and redraw pulses
  logic [DW-1:0] rd_mux, rdata_q;
  logic          err_d, err_q, redraw_q;

  always_comb begin
    case (sel)
      SEL_TIM:   rd_mux = tim_q[tim_idx];
      SEL_UPB,
      SEL_UPCUR: rd_mux = upb_q;
      SEL_LPB,
      SEL_LPCUR: rd_mux = lpb_q;
      SEL_MASK:  rd_mux = DW'(mask_v);
      SEL_CTRL:  rd_mux = DW'(ctrl_q);
      SEL_RIS:   rd_mux = DW'(raw_v);
      SEL_MIS:   rd_mux = DW'(masked_v);
      SEL_ID:    rd_mux = DW'(id_byte(id_idx));
      default:   rd_mux = '0;
    endcase
    err_d = bus_en && (sel == SEL_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_acc) rdata_q <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      redraw_q <= 1'b0;
    end else begin
      err_q    <= err_d;
      redraw_q <= wr_acc;
    end
  end

  assign bus_rdata    = rdata_q;
  assign bus_err      = err_q;
  assign redraw_pulse = redraw_q;

  // R9: a write produces a redraw pulse in the next cycle only
  p_redraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> redraw_pulse);
  p_redraw_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> !redraw_pulse);

  // R10: unmapped access flags an error next cycle
  p_unmapped_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && (bus_addr > AW'(12)) && (bus_addr < AW'((1 << AW) - 8))) |=> bus_err);

  // R11: read data holds when no read is captured
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata));

  // R7: width and height follow their timing writes
  p_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !variant_sel && (bus_addr == AW'(0))) |=>
      (panel_width == WIDTH_W'(((32'($past(bus_wdata[7:0])) & 32'hFC) + 32'd4) * 32'd4)));
  p_height_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (bus_addr == AW'(1))) |=>
      (panel_height == HEIGHT_W'((32'($past(bus_wdata[15:0])) & 32'h3FF) + 32'd1)));

  // R8: a control write with enable and power set enables the controller
  p_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && bus_wdata[CB_EN] && bus_wdata[CB_PWR]) |=> ctrl_enabled);

endmodule

// File: tb/test_lcdc_regs.sv
`timescale 1ns/1ps
module test_lcdc_regs;

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 10'd0,   32'h000000FF, 4'd2},   // R2
    '{1'b0, 10'd0,   32'h000000FF, 4'd2},
    '{1'b1, 10'd1,   32'h00000FFF, 4'd2},
    '{1'b0, 10'd1,   32'h00000FFF, 4'd2},
    '{1'b1, 10'd2,   32'h12345678, 4'd2},
    '{1'b0, 10'd2,   32'h12345678, 4'd2},
    '{1'b1, 10'd3,   32'hCAFE0001, 4'd2},
    '{1'b0, 10'd3,   32'hCAFE0001, 4'd2},
    '{1'b1, 10'd4,   32'hA0000000, 4'd2},
    '{1'b0, 10'd4,   32'hA0000000, 4'd2},
    '{1'b0, 10'd11,  32'hA0000000, 4'd2},
    '{1'b1, 10'd5,   32'hB0000004, 4'd2},
    '{1'b0, 10'd5,   32'hB0000004, 4'd2},
    '{1'b0, 10'd12,  32'hB0000004, 4'd2},
    '{1'b1, 10'd12,  32'h55555555, 4'd2},
    '{1'b0, 10'd5,   32'hB0000004, 4'd2},
    '{1'b1, 10'd7,   32'hFFFF0801, 4'd8},   // R8
    '{1'b0, 10'd7,   32'h00000801, 4'd8},
    '{1'b1, 10'd6,   32'hFFFFFFF5, 4'd4},   // R4
    '{1'b0, 10'd6,   32'h00000005, 4'd4},
    '{1'b0, 10'd8,   32'h00000000, 4'd5},   // R5
    '{1'b0, 10'd10,  32'h00000000, 4'd5},
    '{1'b0, 10'h3F8, 32'h00000010, 4'd6},   // R6
    '{1'b0, 10'h3F9, 32'h00000011, 4'd6},
    '{1'b0, 10'h3FA, 32'h00000004, 4'd6},
    '{1'b0, 10'h3FB, 32'h00000000, 4'd6},
    '{1'b0, 10'h3FC, 32'h0000000D, 4'd6},
    '{1'b0, 10'h3FD, 32'h000000F0, 4'd6},
    '{1'b0, 10'h3FE, 32'h00000005, 4'd6},
    '{1'b1, 10'h3FF, 32'h12345678, 4'd6},
    '{1'b0, 10'h3FF, 32'h000000B1, 4'd6},
    '{1'b0, 10'd13,  32'h00000000, 4'd10},  // R10
    '{1'b0, 10'h3F7, 32'h00000000, 4'd10},
    '{1'b0, 10'd9,   32'h00000000, 4'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we, variant_sel;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_err, irq_out, redraw_pulse, ctrl_enabled;
  logic [3:0]  irq_set;
  logic [10:0] panel_width, panel_height;
  logic [2:0]  pix_depth;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lcdc_regs i_lcdc_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .variant_sel(variant_sel), .irq_set(irq_set),
    .irq_out(irq_out), .redraw_pulse(redraw_pulse),
    .panel_width(panel_width), .panel_height(panel_height),
    .ctrl_enabled(ctrl_enabled), .pix_depth(pix_depth)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_set(input logic [3:0] v);
    @(negedge clk);
    irq_set = v;
    @(negedge clk);
    irq_set = '0;
  endtask

  task automatic idle;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; variant_sel = 1'b0; irq_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 width", 32'(panel_width), 32'd16);
    chk("R1 height", 32'(panel_height), 32'd1);
    chk("R1 irq", 32'(irq_out), 32'd0);
    chk("R1 enabled", 32'(ctrl_enabled), 32'd0);
    chk("R1 redraw", 32'(redraw_pulse), 32'd0);
    bus_rd(10'd0, rd); chk("R1 timing0", rd, 32'd0);
    bus_rd(10'd7, rd); chk("R1 ctrl", rd, 32'd0);
    bus_rd(10'd4, rd); chk("R1 upbase", rd, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      if (VEC[i].wr) begin
        bus_wr(VEC[i].addr, VEC[i].data);
        chk({tag, " redraw"}, 32'(redraw_pulse), 32'd1);
      end else begin
        bus_rd(VEC[i].addr, rd);
        chk(tag, rd, VEC[i].data);
      end
    end

    // R7 geometry
    chk("R7 width 0xFF", 32'(panel_width), 32'd1024);
    chk("R7 height 0xFFF", 32'(panel_height), 32'd1024);
    bus_wr(10'd0, 32'h0000009F); chk("R7 width 640", 32'(panel_width), 32'd640);
    bus_wr(10'd1, 32'h000001DF); chk("R7 height 480", 32'(panel_height), 32'd480);
    bus_wr(10'd0, 32'hFFFFFF03); chk("R7 width 16", 32'(panel_width), 32'd16);

    // R8 enable and depth
    chk("R8 enabled 0x801", 32'(ctrl_enabled), 32'd1);
    bus_wr(10'd7, 32'h00000001); chk("R8 no power", 32'(ctrl_enabled), 32'd0);
    bus_wr(10'd7, 32'h0000080B);
    chk("R8 enabled 0x80B", 32'(ctrl_enabled), 32'd1);
    chk("R8 depth", 32'(pix_depth), 32'd5);

    // R9 single pulse
    idle; chk("R9 redraw drops", 32'(redraw_pulse), 32'd0);

    // R4/R5 interrupts, mask = 0x5
    pulse_set(4'hA);
    chk("R4 masked-out irq", 32'(irq_out), 32'd0);
    bus_rd(10'd8, rd); chk("R5 raw after set", rd, 32'h0000000A);
    pulse_set(4'h1);
    chk("R4 irq asserted", 32'(irq_out), 32'd1);
    bus_rd(10'd9, rd); chk("R4 masked status", rd, 32'h00000001);
    bus_wr(10'd10, 32'h00000003);
    chk("R4 irq after clear", 32'(irq_out), 32'd0);
    bus_rd(10'd8, rd); chk("R5 raw after clear", rd, 32'h00000008);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 10'd10; bus_wdata = 32'h00000006; irq_set = 4'h4;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; irq_set = '0;
    bus_rd(10'd8, rd); chk("R5 set wins over clear", rd, 32'h0000000C);
    chk("R4 irq from bit2", 32'(irq_out), 32'd1);
    bus_wr(10'd10, 32'h0000000C);
    bus_rd(10'd8, rd); chk("R5 all cleared", rd, 32'd0);

    // R3 variant swap
    variant_sel = 1'b1;
    bus_rd(10'd6, rd); chk("R3 off6 is ctrl", rd, 32'h0000080B);
    bus_rd(10'd7, rd); chk("R3 off7 is mask", rd, 32'h00000005);
    bus_wr(10'd6, 32'h00000001); chk("R3 ctrl write at 6", 32'(ctrl_enabled), 32'd0);
    bus_wr(10'd7, 32'h00000003);
    variant_sel = 1'b0;
    bus_rd(10'd6, rd); chk("R3 mask back at 6", rd, 32'h00000003);
    bus_rd(10'd7, rd); chk("R3 ctrl back at 7", rd, 32'h00000001);

    // R10 errors
    bus_rd(10'd13, rd);
    chk("R10 read err", 32'(bus_err), 32'd1);
    idle; chk("R10 err drops", 32'(bus_err), 32'd0);
    bus_wr(10'h100, 32'hFFFFFFFF);
    chk("R10 write err", 32'(bus_err), 32'd1);
    chk("R9 redraw on unmapped", 32'(redraw_pulse), 32'd1);
    bus_rd(10'd0, rd);
    chk("R10 mapped no err", 32'(bus_err), 32'd0);
    chk("R10 timing0 untouched", rd, 32'hFFFFFF03);
    bus_wr(10'h3FC, 32'h0);
    chk("R6 id write no err", 32'(bus_err), 32'd0);

    // R11 latency and hold
    bus_rd(10'd2, rd); chk("R11 read", rd, 32'h12345678);
    bus_wr(10'd3, 32'h0);
    idle; chk("R11 hold", bus_rdata, 32'h12345678);

    // R1 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 mid width", 32'(panel_width), 32'd16);
    chk("R1 mid rdata", bus_rdata, 32'd0);
    bus_rd(10'd4, rd); chk("R1 mid upbase", rd, 32'd0);
    bus_rd(10'd6, rd); chk("R1 mid mask", rd, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule